// File: doc/BRIEF.md
# JTAG Flash Programming Command Data Register

This block is a test-access-port data register that carries programming commands from a JTAG debugger to an on-chip flash controller. It is active only when the instruction register holds the programming-command opcode. It is driven by the capture, shift, update and run-test/idle state strobes of an external TAP controller, all sampled on the rising edge of TCK.

On capture, the register loads the result word that the flash controller returned for the previous command. During shift, that result leaves on TDO while the next command enters from TDI. On update, the new command is copied to a parallel command bus that holds its value. On entry into run-test/idle, the block raises one execute strobe so that the controller runs the applied command. A debugger therefore reads the result of command N while it loads command N+1.

Top module: `jtag_prog_cmd_dr`

## Requirements
- R1: While `trst_n` is low, `cmd_out` is 0, `exec_pulse` is 0 and the shift register is 0. `tdo` therefore reads 0 once the register is selected.
- R2: When the register is selected, a rising TCK edge with `st_capture` high loads `result_in` into the 15-bit shift register.
- R3: When the register is selected, each rising TCK edge with `st_shift` high shifts the register one place toward bit 0. `tdi` enters at bit 14, and `tdo` always shows bit 0. A captured word therefore leaves LSB first over 15 shifts.
- R4: When the register is selected, a rising TCK edge with `st_update` high copies the shift register to `cmd_out`.
- R5: `cmd_out` changes on no edge other than a selected update or reset. Shifting, capturing and idling leave it unchanged.
- R6: When the register is selected, `exec_pulse` is high for exactly one TCK cycle after the first edge on which `st_idle` is high. It stays low for the rest of that idle stay and pulses again only on a new entry into idle.
- R7: Only the instruction code 0x5 on `ir_value` selects the register. With any other code, all four strobes have no effect on the shift register, on `cmd_out` or on `exec_pulse`, and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| ir_value | input | IR_W (4) | Current instruction register contents |
| st_capture | input | 1 | TAP controller is in Capture-DR |
| st_shift | input | 1 | TAP controller is in Shift-DR |
| st_update | input | 1 | TAP controller is in Update-DR |
| st_idle | input | 1 | TAP controller is in Run-Test/Idle |
| tdi | input | 1 | Serial test data in |
| result_in | input | CMD_W (15) | Result of the previous command from the flash controller |
| tdo | output | 1 | Serial test data out (bit 0 of the shift register) |
| cmd_out | output | CMD_W (15) | Latched command word driving the flash controller |
| exec_pulse | output | 1 | One-cycle strobe that executes the applied command |

## Verification
The bench targets four corner cases:

- **Long idle stays.** The bench holds idle for several cycles and counts strobes. A design that pulses once per idle cycle would report more than one.
- **Shift order.** The bench checks bit order by reading a captured asymmetric word back serially. A reversed shift would return a mirrored word.
- **Shifting without an update.** After shifting a word in with no update, the bench confirms that `cmd_out` has kept the earlier command. A design that drives the bus straight from the shift register would leak partial words.
- **Deselection.** The bench runs every strobe under neighbouring opcodes, then reselects and shifts out. A design that ignores the opcode would show a clobbered register, a changed command or a stray strobe.

// File: rtl/jtag_prog_cmd_dr.sv
module jtag_prog_cmd_dr #(
  parameter int unsigned CMD_W    = 15,
  parameter int unsigned IR_W     = 4,
  parameter int unsigned SEL_CODE = 5
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [IR_W-1:0]  ir_value,
  input  logic             st_capture,
  input  logic             st_shift,
  input  logic             st_update,
  input  logic             st_idle,
  input  logic             tdi,
  input  logic [CMD_W-1:0] result_in,
  output logic             tdo,
  output logic [CMD_W-1:0] cmd_out,
  output logic             exec_pulse
);

  localparam logic [IR_W-1:0] SEL = IR_W'(SEL_CODE);

  logic             sel;
  logic [CMD_W-1:0] sr;
  logic             idle_q;

  assign sel = (ir_value == SEL);
  assign tdo = sel & sr[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      sr <= '0;
    else if (sel && st_capture)
      sr <= result_in;
    else if (sel && st_shift)
      sr <= {tdi, sr[CMD_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      cmd_out <= '0;
    else if (sel && st_update)
      cmd_out <= sr;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      idle_q     <= 1'b0;
      exec_pulse <= 1'b0;
    end else begin
      idle_q     <= st_idle;
      exec_pulse <= sel & st_idle & ~idle_q;
    end
  end

endmodule

module jtag_prog_cmd_dr_chk #(
  parameter int unsigned CMD_W    = 15,
  parameter int unsigned IR_W     = 4,
  parameter int unsigned SEL_CODE = 5
) (
  input logic             tck,
  input logic             trst_n,
  input logic [IR_W-1:0]  ir_value,
  input logic             st_capture,
  input logic             st_shift,
  input logic             st_update,
  input logic             st_idle,
  input logic             tdi,
  input logic [CMD_W-1:0] result_in,
  input logic [CMD_W-1:0] sr,
  input logic [CMD_W-1:0] cmd_out,
  input logic             exec_pulse
);
  logic selc;
  assign selc = (ir_value == IR_W'(SEL_CODE));

  // R1
  reset_clear_chk: assert property (@(posedge tck) !trst_n |-> (cmd_out == '0 && !exec_pulse));

  // R2
  capture_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (selc && st_capture) |=> sr == $past(result_in));

  // R3
  shift_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (selc && st_shift && !st_capture) |=>
      (sr[CMD_W-2:0] == $past(sr[CMD_W-1:1]) && sr[CMD_W-1] == $past(tdi)));

  // R4
  update_copy_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (selc && st_update) |=> cmd_out == $past(sr));

  // R5
  cmd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(selc && st_update) |=> $stable(cmd_out));

  // R6
  exec_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
    exec_pulse |=> !exec_pulse);

  // R6
  exec_cause_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(exec_pulse) |-> ($past(st_idle) && $past(selc)));

  // R7
  unsel_keep_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !selc |=> $stable(sr));
endmodule

bind jtag_prog_cmd_dr jtag_prog_cmd_dr_chk #(
  .CMD_W(CMD_W), .IR_W(IR_W), .SEL_CODE(SEL_CODE)
) u_chk (
  .tck(tck), .trst_n(trst_n), .ir_value(ir_value),
  .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
  .st_idle(st_idle), .tdi(tdi), .result_in(result_in), .sr(sr),
  .cmd_out(cmd_out), .exec_pulse(exec_pulse)
);

// File: tb/sim_jtag_prog_cmd_dr.sv
module sim_jtag_prog_cmd_dr;
  localparam int W = 15;

  logic         tck = 0;
  logic         trst_n = 0;
  logic [3:0]   ir_value = 4'h5;
  logic         st_capture = 0, st_shift = 0, st_update = 0, st_idle = 0, tdi = 0;
  logic [W-1:0] result_in = '0;
  logic         tdo;
  logic [W-1:0] cmd_out;
  logic         exec_pulse;

  int n_chk = 0, n_fail = 0;

  always #5 tck = ~tck;

  jtag_prog_cmd_dr u0 (
    .tck(tck), .trst_n(trst_n), .ir_value(ir_value),
    .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
    .st_idle(st_idle), .tdi(tdi), .result_in(result_in),
    .tdo(tdo), .cmd_out(cmd_out), .exec_pulse(exec_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic u, input logic i, input logic d);
    @(negedge tck);
    st_capture = c; st_shift = s; st_update = u; st_idle = i; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_word(input logic [W-1:0] din, output logic [W-1:0] dout);
    for (int k = 0; k < W; k++) begin
      @(negedge tck);
      st_capture = 0; st_shift = 1; st_update = 0; st_idle = 0; tdi = din[k];
      dout[k] = tdo;
      @(posedge tck); #1;
    end
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 cmd_out", 32'(cmd_out), 0);
    chk("R1 exec_pulse", 32'(exec_pulse), 0);
    chk("R1 tdo", 32'(tdo), 0);
  endtask

  task automatic t_capture_update;
    logic [W-1:0] got;
    result_in = 15'h5A3C;
    step(1, 0, 0, 0, 0);
    chk("R2 tdo after capture", 32'(tdo), 32'(result_in[0]));
    result_in = 15'h0F0F;
    shift_word(15'h1234, got);
    chk("R3 captured word shifted out LSB first", 32'(got), 32'h5A3C);
    chk("R5 cmd_out before update", 32'(cmd_out), 0);
    step(0, 0, 1, 0, 0);
    chk("R4 cmd_out after update", 32'(cmd_out), 32'h1234);
    step(1, 0, 0, 0, 0);
    shift_word(15'h7001, got);
    chk("R2 second capture", 32'(got), 32'h0F0F);
  endtask

  task automatic t_hold;
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 cmd_out held without update", 32'(cmd_out), 32'h1234);
    step(0, 0, 1, 0, 0);
    chk("R4 second update", 32'(cmd_out), 32'h0F0F);
  endtask

  task automatic t_exec;
    int cnt = 0;
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 1, 0);
      if (exec_pulse) cnt++;
      if (k == 0) chk("R6 pulse on first idle edge", 32'(exec_pulse), 1);
    end
    step(0, 0, 0, 0, 0);
    if (exec_pulse) cnt++;
    chk("R6 one pulse per idle stay", 32'(cnt), 1);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 1, 0);
      if (exec_pulse) cnt++;
    end
    step(0, 0, 0, 0, 0);
    chk("R6 pulse on re-entry", 32'(cnt), 1);
  endtask

  task automatic t_unselected(input logic [3:0] code);
    logic [W-1:0] got;
    int cnt = 0;
    logic tdo_seen = 0;
    result_in = 15'h7FFF;
    @(negedge tck); ir_value = code;
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < W; k++) begin
      step(0, 1, 0, 0, 1);
      tdo_seen |= tdo;
    end
    step(0, 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 1, 0);
      if (exec_pulse) cnt++;
    end
    step(0, 0, 0, 0, 0);
    chk("R7 tdo low when unselected", 32'(tdo_seen), 0);
    chk("R7 no exec when unselected", 32'(cnt), 0);
    chk("R7 cmd_out kept when unselected", 32'(cmd_out), 32'h0F0F);
    @(negedge tck); ir_value = 4'h5;
    shift_word(15'h0F0F, got);
    chk("R7 shift register kept when unselected", 32'(got), 32'h0F0F);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    t_reset;
    @(negedge tck); trst_n = 1;
    t_capture_update;
    t_hold;
    t_exec;
    t_unselected(4'h4);
    t_unselected(4'h6);
    t_unselected(4'hD);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule